// File: doc/BRIEF.md
# Serial Configuration Register File with Staged Commit

This block is the configuration port of a mixed-signal core. An external host reaches it over a three-wire serial link: a serial clock, an active-low select, and one data line that turns around during reads. The pad is split into `sdi`, `sdo` and an output enable `sdo_oe`. The chip's own clock samples all three serial pins through a synchronizer. The serial clock must therefore stay low and high for at least `SYNC_STAGES + 3` system clocks per half period.

Each frame begins with a 16-bit instruction. Bit 15 is read (1) or write (0). Bits 14:13 give the byte count. Bits 12:0 give the start address. Data bytes follow the instruction. A bank of function registers is staged: a write changes only its staging copy. All staging copies move to the live copies, which drive `live_regs`, in one clock when the host writes a set bit 0 to the commit address. The space also holds a configuration register with a mirrored layout, two read-only identity bytes, and a soft reset.

Top module: `spi_cfg_regfile`

## Requirements
- R1: After reset `sdo_oe` is low and every live byte is zero, except the byte at address 0x09, which is 0x01. Chip select low starts a frame, and `sdi` is sampled on rising serial clock edges. Chip select high returns the block to idle with `sdo_oe` low.
- R2: The instruction word is R/W in bit 15 (1 = read), count in bits 14:13 and address in bits 12:0. In MSB-first order bit 15 goes on the line first.
- R3: Count 00, 01 and 10 move 1, 2 and 3 bytes. Data bytes beyond the count have no effect. Count 11 keeps moving bytes until chip select rises.
- R4: After each byte the address goes down by one in MSB-first frames and up by one in LSB-first frames.
- R5: In a read, `sdo_oe` rises at the first falling serial clock edge after the last instruction bit. Each data bit is driven from a falling edge so that it is valid at the next rising edge. No extra bytes are driven. `sdo_oe` never rises in a write frame.
- R6: Addresses 0x08 to 0x18 are staging registers that read back what was written. Live bytes keep their value until 0x01 is written to 0xFF. That write copies all staging bytes to live in one step. Address 0xFF reads as 0x00.
- R7: Address 0x01 returns CHIP_ID and address 0x02 returns GRADE_ID. Writes to them have no effect.
- R8: Writes to undefined addresses such as 0x19 or 0x30 have no effect. Reads from them return 0x00.
- R9: Address 0x00 resets to 0x18. Bit i always equals bit 7-i, and a write to either mirror sets both. LSB-first order is selected by bit 1 (or bit 6) and applies from the next frame.
- R10: A write to address 0x00 with bit 2 (or bit 5) set returns every register to its reset value. This includes the live bytes and address 0x00, which reads 0x18 again.
- R11: If chip select rises in the middle of a byte, that byte is dropped and the next frame decodes normally.
- R12: In LSB-first frames, the instruction word and every data byte go on the line bit 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the pad |
| sdo_oe | output | 1 | Pad drive enable for `sdo` |
| live_regs | output | SHADOW_CNT*8 | Live function bytes; byte i is address SHADOW_LO+i |

## Verification
The bench builds the block with CHIP_ID 0x5C and GRADE_ID 0x03 instead of the defaults, so the identity reads cannot pass by matching a reset pattern. It keeps SHADOW_CNT at 17 and SHADOW_LO at 8. This puts the last staging byte (0x18) and the first undefined address (0x19) within one two-byte read, so the top edge of the bank can be checked. With two synchronizer stages and a serial half period of six clocks, the bench can toggle bit order and soft reset between frames and can observe how descending and ascending address steps cross read-only and undefined locations.

// File: rtl/spi_cfg_pkg.sv
`timescale 1ns/1ps
package spi_cfg_pkg;
  localparam int INSTR_BITS = 16;
  localparam int ADDR_W     = 13;

  typedef enum logic [1:0] {FR_IDLE, FR_INSTR, FR_DATA, FR_DONE} frame_state_e;

  localparam logic [ADDR_W-1:0] ADDR_CFG   = 13'h000;
  localparam logic [ADDR_W-1:0] ADDR_CHIP  = 13'h001;
  localparam logic [ADDR_W-1:0] ADDR_GRADE = 13'h002;
  localparam logic [ADDR_W-1:0] ADDR_XFER  = 13'h0FF;
  localparam logic [7:0]        CFG_DEFAULT = 8'h18;

  // builds a config byte whose upper nibble is the bit-reverse of the lower
  function automatic logic [7:0] mirror_cfg(input logic [3:0] lo);
    return {lo[0], lo[1], lo[2], lo[3], lo};
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic sdi_s
);
  logic [STAGES-1:0] sclk_p, cs_p, sdi_p;
  logic              sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      sdi_p  <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
      cs_p   <= {cs_p[STAGES-2:0], cs_n_i};
      sdi_p  <= {sdi_p[STAGES-2:0], sdi_i};
      sclk_d <= sclk_p[STAGES-1];
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_d;
  assign cs_act    = ~cs_p[STAGES-1];
  assign sdi_s     = sdi_p[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/1ps
module spi_frame_ctrl
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_act,
  input  logic              sdi_s,
  input  logic              lsb_cfg,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  frame_state_e            st_q;
  logic [3:0]              bit_q;
  logic [INSTR_BITS-1:0]   ins_q, ins_nx;
  logic [7:0]              byte_q, byte_nx, tx_q;
  logic                    rd_q, lsb_q, sdo_q, oe_q, wr_q;
  logic [1:0]              cnt_q, done_q;
  logic [ADDR_W-1:0]       addr_q, wa_q;
  logic [7:0]              wd_q;
  logic                    last_byte;

  assign ins_nx    = lsb_q ? {sdi_s, ins_q[INSTR_BITS-1:1]} : {ins_q[INSTR_BITS-2:0], sdi_s};
  assign byte_nx   = lsb_q ? {sdi_s, byte_q[7:1]} : {byte_q[6:0], sdi_s};
  assign last_byte = (cnt_q != 2'b11) && (done_q == cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FR_IDLE;  bit_q <= '0;  ins_q <= '0;  byte_q <= '0;  tx_q <= '0;
      rd_q <= 1'b0;     lsb_q <= 1'b0; sdo_q <= 1'b0; oe_q <= 1'b0; wr_q <= 1'b0;
      cnt_q <= '0;      done_q <= '0; addr_q <= '0; wa_q <= '0;   wd_q <= '0;
    end else begin
      wr_q <= 1'b0;
      if (!cs_act) begin
        st_q  <= FR_IDLE;
        oe_q  <= 1'b0;
        bit_q <= '0;
      end else begin
        case (st_q)
          FR_IDLE: begin
            st_q  <= FR_INSTR;
            lsb_q <= lsb_cfg;
            bit_q <= '0;
          end
          FR_INSTR: if (sclk_rise) begin
            ins_q <= ins_nx;
            bit_q <= bit_q + 4'd1;
            if (bit_q == 4'(INSTR_BITS - 1)) begin
              rd_q   <= ins_nx[15];
              cnt_q  <= ins_nx[14:13];
              addr_q <= ins_nx[ADDR_W-1:0];
              done_q <= '0;
              bit_q  <= '0;
              st_q   <= FR_DATA;
            end
          end
          FR_DATA: begin
            if (sclk_rise) begin
              byte_q <= byte_nx;
              bit_q  <= bit_q + 4'd1;
              if (bit_q == 4'd7) begin
                bit_q  <= '0;
                done_q <= done_q + 2'd1;
                addr_q <= lsb_q ? addr_q + 13'd1 : addr_q - 13'd1;
                if (!rd_q) begin
                  wr_q <= 1'b1;
                  wa_q <= addr_q;
                  wd_q <= byte_nx;
                end
                if (last_byte) begin
                  st_q <= FR_DONE;
                  oe_q <= 1'b0;
                end
              end
            end else if (sclk_fall && rd_q) begin
              oe_q <= 1'b1;
              if (bit_q == 4'd0) begin
                sdo_q <= lsb_q ? rd_data[0] : rd_data[7];
                tx_q  <= lsb_q ? {1'b0, rd_data[7:1]} : {rd_data[6:0], 1'b0};
              end else begin
                sdo_q <= lsb_q ? tx_q[0] : tx_q[7];
                tx_q  <= lsb_q ? {1'b0, tx_q[7:1]} : {tx_q[6:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr = addr_q;
  assign wr_en   = wr_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign sdo     = sdo_q;
  assign sdo_oe  = oe_q;

  a_r5_oe_read: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> rd_q);
  a_r1_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (st_q == FR_IDLE && !sdo_oe));
  a_r3_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FR_DATA) |-> (bit_q < 4'd8));
  a_r11_wr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(st_q == FR_DATA && cs_act));
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank
  import spi_cfg_pkg::*;
#(
  parameter int         SHADOW_LO  = 8,
  parameter int         SHADOW_CNT = 17,
  parameter logic [7:0] CHIP_ID    = 8'h2B,
  parameter logic [7:0] GRADE_ID   = 8'h01,
  parameter int         STAB_IDX   = 1,
  parameter logic [7:0] STAB_DEF   = 8'h01
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [7:0]              wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  output logic                    lsb_first,
  output logic [SHADOW_CNT*8-1:0] live_flat
);
  logic [7:0] cfg_q;
  logic [7:0] shadow_q [SHADOW_CNT];
  logic [7:0] live_q   [SHADOW_CNT];
  logic [3:0] cfg_lo_nx;
  logic       cfg_hit, srst_hit, xfer_hit;

  function automatic logic [7:0] def_of(input int idx);
    return (idx == STAB_IDX) ? STAB_DEF : 8'h00;
  endfunction

  // either mirror copy of a config bit turns it on
  assign cfg_lo_nx = wr_data[3:0] | {wr_data[4], wr_data[5], wr_data[6], wr_data[7]};
  assign cfg_hit   = wr_en && (wr_addr == ADDR_CFG);
  assign srst_hit  = cfg_hit && cfg_lo_nx[2];
  assign xfer_hit  = wr_en && (wr_addr == ADDR_XFER) && wr_data[0];
  assign lsb_first = cfg_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_DEFAULT;
      for (int i = 0; i < SHADOW_CNT; i++) begin
        shadow_q[i] <= def_of(i);
        live_q[i]   <= def_of(i);
      end
    end else if (srst_hit) begin
      cfg_q <= CFG_DEFAULT;
      for (int i = 0; i < SHADOW_CNT; i++) begin
        shadow_q[i] <= def_of(i);
        live_q[i]   <= def_of(i);
      end
    end else begin
      if (cfg_hit) cfg_q <= mirror_cfg(cfg_lo_nx);
      for (int i = 0; i < SHADOW_CNT; i++) begin
        if (wr_en && wr_addr == 13'(SHADOW_LO + i)) shadow_q[i] <= wr_data;
        if (xfer_hit) live_q[i] <= shadow_q[i];
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == ADDR_CFG)   rd_data = cfg_q;
    if (rd_addr == ADDR_CHIP)  rd_data = CHIP_ID;
    if (rd_addr == ADDR_GRADE) rd_data = GRADE_ID;
    for (int i = 0; i < SHADOW_CNT; i++)
      if (rd_addr == 13'(SHADOW_LO + i)) rd_data = shadow_q[i];
  end

  for (genvar g = 0; g < SHADOW_CNT; g++) begin : g_live
    assign live_flat[8*g +: 8] = live_q[g];
  end

  a_r9_cfg_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[7:4] == {cfg_q[0], cfg_q[1], cfg_q[2], cfg_q[3]});
  a_r6_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_hit && !srst_hit) |=> $stable(live_flat));
  a_r10_srst_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hit |=> (cfg_q == CFG_DEFAULT));
endmodule

// File: rtl/spi_cfg_regfile.sv
`timescale 1ns/1ps
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         SHADOW_LO   = 8,
  parameter int         SHADOW_CNT  = 17,
  parameter logic [7:0] CHIP_ID     = 8'h2B,
  parameter logic [7:0] GRADE_ID    = 8'h01,
  parameter int         STAB_IDX    = 1,
  parameter logic [7:0] STAB_DEF    = 8'h01
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclk,
  input  logic                    cs_n,
  input  logic                    sdi,
  output logic                    sdo,
  output logic                    sdo_oe,
  output logic [SHADOW_CNT*8-1:0] live_regs
);
  logic              sclk_rise, sclk_fall, cs_act, sdi_s, lsb_first, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [7:0]        rd_data, wr_data;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .sdi_s(sdi_s)
  );

  spi_frame_ctrl u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_act(cs_act), .sdi_s(sdi_s), .lsb_cfg(lsb_first), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  cfg_reg_bank #(
    .SHADOW_LO(SHADOW_LO), .SHADOW_CNT(SHADOW_CNT), .CHIP_ID(CHIP_ID),
    .GRADE_ID(GRADE_ID), .STAB_IDX(STAB_IDX), .STAB_DEF(STAB_DEF)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lsb_first(lsb_first), .live_flat(live_regs)
  );
endmodule

// File: tb/sim_spi_cfg_regfile.sv
`timescale 1ns/1ps
module sim_spi_cfg_regfile;
  localparam int HP = 6;
  localparam logic [7:0] CHIP = 8'h5C;
  localparam logic [7:0] GRADE = 8'h03;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [135:0] live_regs;
  int n_chk = 0, n_err = 0;
  bit lsb_mode = 1'b0;
  logic [7:0] exp_val[$];
  string      exp_tag[$];

  always #10 clk = ~clk;

  spi_cfg_regfile #(.SYNC_STAGES(2), .SHADOW_LO(8), .SHADOW_CNT(17),
    .CHIP_ID(CHIP), .GRADE_ID(GRADE)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .live_regs(live_regs));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_val.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    repeat (HP) @(negedge clk);
    sclk = 1'b1;
    repeat (HP) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic frame(input bit rd, input logic [1:0] w, input logic [12:0] a, input int nb,
                       input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [15:0] iw;
    logic [7:0]  db [3];
    iw = {rd, w, a};
    db[0] = d0; db[1] = d1; db[2] = d2;
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < 16; i++) send_bit(lsb_mode ? iw[i] : iw[15-i]);
    for (int k = 0; k < nb; k++)
      for (int i = 0; i < 8; i++) send_bit(lsb_mode ? db[k%3][i] : db[k%3][7-i]);
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HP) @(negedge clk);
    check(sdo_oe == 1'b0, "R1 R5 oe released", 32'(sdo_oe), 0);
    if (rd) check(exp_val.size() == 0, "R5 all read bytes delivered", exp_val.size(), 0);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    frame(1'b0, 2'b00, a, 1, d, 8'h00, 8'h00);
  endtask

  task automatic rd(input logic [1:0] w, input logic [12:0] a, input int nb);
    frame(1'b1, w, a, nb, 8'h00, 8'h00, 8'h00);
  endtask

  function automatic logic [7:0] live(input int i);
    return live_regs[8*i +: 8];
  endfunction

  // monitor: assembles driven bytes and scores them against the queue
  initial begin : mon
    int nb;
    logic [7:0] acc;
    nb = 0; acc = '0;
    forever begin
      @(posedge sclk or posedge cs_n);
      if (cs_n) nb = 0;
      else if (sdo_oe) begin
        acc = lsb_mode ? {sdo, acc[7:1]} : {acc[6:0], sdo};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_val.size() == 0) check(1'b0, "R3 R5 unexpected byte", acc, 0);
          else begin
            logic [7:0] e;
            string t;
            e = exp_val.pop_front();
            t = exp_tag.pop_front();
            check(acc == e, t, acc, e);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sdo_oe == 1'b0, "R1 oe after reset", 32'(sdo_oe), 0);
    check(live(1) == 8'h01, "R1 live 0x09 default", live(1), 8'h01);
    check(live(0) == 8'h00 && live(16) == 8'h00, "R1 live defaults zero", {live(16), live(0)}, 0);

    // R2 R4 R7 R9: 3-byte read descending from 0x02
    expect_rd(GRADE, "R2 R7 grade id");
    expect_rd(CHIP, "R4 R7 chip id");
    expect_rd(8'h18, "R4 R9 config default");
    rd(2'b10, 13'h002, 3);

    // R4 R6: 3-byte write descending from 0x0A, live untouched
    frame(1'b0, 2'b10, 13'h00A, 3, 8'h11, 8'h22, 8'h33);
    check(live(2) == 8'h00 && live(1) == 8'h01 && live(0) == 8'h00, "R6 live holds before commit",
          {live(2), live(1), live(0)}, 32'h000100);
    // R3: streaming read ends at chip select
    expect_rd(8'h11, "R3 stream byte 0");
    expect_rd(8'h22, "R3 stream byte 1");
    expect_rd(8'h33, "R3 stream byte 2");
    rd(2'b11, 13'h00A, 3);

    // R6: commit
    wr1(13'h0FF, 8'h01);
    check({live(2), live(1), live(0)} == 24'h112233, "R6 commit copies all",
          {live(2), live(1), live(0)}, 32'h112233);
    expect_rd(8'h00, "R6 commit reads zero");
    rd(2'b00, 13'h0FF, 1);

    // R3: extra byte beyond count ignored
    frame(1'b0, 2'b00, 13'h00B, 2, 8'h44, 8'h55, 8'h00);
    expect_rd(8'h44, "R3 counted byte");
    expect_rd(8'h11, "R3 extra byte ignored");
    rd(2'b01, 13'h00B, 2);

    // R7 R8 R6: read-only, undefined, top staging address
    wr1(13'h001, 8'h99);
    wr1(13'h030, 8'h77);
    wr1(13'h018, 8'hEE);
    wr1(13'h019, 8'h66);
    expect_rd(CHIP, "R7 write to id ignored");
    rd(2'b00, 13'h001, 1);
    expect_rd(8'h00, "R8 undefined 0x19 reads zero");
    expect_rd(8'hEE, "R6 last staging byte");
    rd(2'b01, 13'h019, 2);
    expect_rd(8'h00, "R8 undefined 0x30 reads zero");
    rd(2'b00, 13'h030, 1);

    // R11: abort mid-byte
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < 16; i++) send_bit(i == 15 ? 1'b0 : ((16'h000C >> (15 - i)) & 1) != 0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HP) @(negedge clk);
    expect_rd(8'h00, "R11 partial byte dropped");
    rd(2'b00, 13'h00C, 1);
    expect_rd(8'h44, "R11 next frame decodes");
    rd(2'b00, 13'h00B, 1);

    // R9 R12 R4: switch to LSB-first via bit 1
    wr1(13'h000, 8'h02);
    lsb_mode = 1'b1;
    expect_rd(8'h42, "R9 R12 mirrored config");
    rd(2'b00, 13'h000, 1);
    frame(1'b0, 2'b01, 13'h008, 2, 8'hA5, 8'h5A, 8'h00);
    expect_rd(8'hA5, "R4 R12 ascending byte 0");
    expect_rd(8'h5A, "R4 R12 ascending byte 1");
    rd(2'b01, 13'h008, 2);
    wr1(13'h0FF, 8'h01);
    check(live(0) == 8'hA5 && live(1) == 8'h5A, "R6 R12 commit in lsb order",
          {live(1), live(0)}, 32'h5AA5);
    wr1(13'h000, 8'h18);
    lsb_mode = 1'b0;
    expect_rd(8'h18, "R9 back to msb order");
    rd(2'b00, 13'h000, 1);

    // R10: soft reset through bit 2
    wr1(13'h000, 8'h04);
    check(live(0) == 8'h00 && live(1) == 8'h01, "R10 live restored", {live(1), live(0)}, 32'h0100);
    expect_rd(8'h18, "R10 config restored");
    rd(2'b00, 13'h000, 1);
    expect_rd(8'h01, "R10 staging 0x09 restored");
    expect_rd(8'h00, "R10 staging 0x08 restored");
    rd(2'b01, 13'h009, 2);

    check(exp_val.size() == 0, "R5 queue drained", exp_val.size(), 0);
    summary();
    $finish;
  end
endmodule